// File: doc/BRIEF.md
# Sixteen-Function Arithmetic Logic Unit with Carry

This block is a purely combinational arithmetic logic unit for a datapath of width `W` (32 by default). A 4-bit operation select picks one of sixteen functions of two operands and an incoming carry: add, subtract and reverse subtract (each with and without the carry), the bitwise AND, OR, XOR and AND-with-inverted-B, pass A, pass B, invert B, the low word of a product, and the constants zero and one.

Next to the result it drives negative, zero, carry and overflow flags. For the six arithmetic functions, carry and overflow come from one shared adder. For every other function they repeat the incoming carry and overflow values, so the register that holds the flags can load all four every cycle. Holding the flags, shifting the operands and accumulating products are the job of the surrounding datapath.

Top module: `alu16_core`

## Requirements
- R1: Select 0000 gives A+B with carry-in 0, and select 1000 gives A+B+carry_in. For both, flag_c is the carry out of the W-bit sum.
- R2: Select 0001 gives A+~B+1 (A−B), and select 1001 gives A+~B+carry_in. For both, flag_c is the adder carry, so 1 means no borrow.
- R3: Select 1010 gives B+~A+1 (B−A), and select 1011 gives B+~A+carry_in. For both, flag_c is the adder carry.
- R4: For the six arithmetic selects, flag_v is set exactly when the two's-complement result is outside the signed W-bit range.
- R5: Select 0010 gives A AND B, 0011 gives A OR B, 0100 gives A XOR B, and 1100 gives A AND NOT B.
- R6: Select 0101 passes A, 0110 passes B, and 1101 gives NOT B.
- R7: Select 0111 gives the low W bits of the unsigned product A×B.
- R8: Select 1110 gives all zeros, and select 1111 gives the value 1.
- R9: For all ten non-arithmetic selects, flag_c equals carry_in and flag_v equals ovf_in.
- R10: For every select, flag_n equals result bit W-1, and flag_z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | Operand A |
| op_b | input | W | Operand B |
| op_sel | input | 4 | Function select |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| result | output | W | Function result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The checker checks some properties whenever the inputs settle. These are the negative and zero flag rules for every select, the pass-through of carry and overflow for the non-arithmetic selects, the plain-add sum and its signed overflow, the no-borrow carry of plain subtract, pass A and the zero constant. The bench's scenarios cover the rest: the carry-dependent forms, reverse subtract, the logic functions, the product, and the corner operands 0, all-ones, 0x80000000 and 0x7FFFFFFF paired against each other with both carry values. These are compared with a signed and unsigned model written in the bench's own terms.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    SEL_ADD  = 4'b0000,
    SEL_SUB  = 4'b0001,
    SEL_AND  = 4'b0010,
    SEL_OR   = 4'b0011,
    SEL_XOR  = 4'b0100,
    SEL_PA   = 4'b0101,
    SEL_PB   = 4'b0110,
    SEL_MUL  = 4'b0111,
    SEL_ADC  = 4'b1000,
    SEL_SBC  = 4'b1001,
    SEL_RSB  = 4'b1010,
    SEL_RSC  = 4'b1011,
    SEL_BIC  = 4'b1100,
    SEL_NOTB = 4'b1101,
    SEL_ZERO = 4'b1110,
    SEL_ONE  = 4'b1111
  } alu_sel_e;

  // True for the six selects that route through the shared adder
  function automatic logic sel_is_arith(input alu_sel_e s);
    return (s == SEL_ADD) || (s == SEL_SUB) || (s == SEL_ADC) ||
           (s == SEL_SBC) || (s == SEL_RSB) || (s == SEL_RSC);
  endfunction

  // Carry injected into the adder for a given select
  function automatic logic sel_carry(input alu_sel_e s, input logic cin);
    case (s)
      SEL_SUB, SEL_RSB:          return 1'b1;
      SEL_ADC, SEL_SBC, SEL_RSC: return cin;
      default:                   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int XW = W + 1;

  logic [XW-1:0] wide;

  always_comb begin
    wide = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (lhs[W-1] == rhs[W-1]) && (sum[W-1] != lhs[W-1]);
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_sel_e     sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] prod_lo;

  always_comb begin
    prod_lo = a * b;
    case (sel)
      SEL_AND:  res = a & b;
      SEL_OR:   res = a | b;
      SEL_XOR:  res = a ^ b;
      SEL_BIC:  res = a & ~b;
      SEL_PA:   res = a;
      SEL_PB:   res = b;
      SEL_NOTB: res = ~b;
      SEL_MUL:  res = prod_lo;
      SEL_ONE:  res = ONE_W;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         arith,
  input  logic         add_c,
  input  logic         add_v,
  input  logic         c_keep,
  input  logic         v_keep,
  output logic         n,
  output logic         z,
  output logic         c,
  output logic         v
);
  always_comb begin
    n = res[W-1];
    z = (res == '0);
    c = arith ? add_c : c_keep;
    v = arith ? add_v : v_keep;
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic         carry_in,
  input  logic         ovf_in,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  alu_sel_e     sel;
  logic         arith_sel;
  logic [W-1:0] add_lhs, add_rhs, add_sum, logic_res;
  logic         add_cin, add_cout, add_ovf;

  assign sel       = alu_sel_e'(op_sel);
  assign arith_sel = sel_is_arith(sel);
  assign add_cin   = sel_carry(sel, carry_in);

  // Reverse forms swap the operands; subtract forms invert the subtrahend
  always_comb begin
    case (sel)
      SEL_SUB, SEL_SBC: begin add_lhs = op_a; add_rhs = ~op_b; end
      SEL_RSB, SEL_RSC: begin add_lhs = op_b; add_rhs = ~op_a; end
      default:          begin add_lhs = op_a; add_rhs = op_b;  end
    endcase
  end

  alu16_addsub #(.W(W)) addsub_i (
    .lhs(add_lhs), .rhs(add_rhs), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu16_logic #(.W(W)) logic_i (
    .sel(sel), .a(op_a), .b(op_b), .res(logic_res)
  );

  assign result = arith_sel ? add_sum : logic_res;

  alu16_flags #(.W(W)) flags_i (
    .res(result), .arith(arith_sel), .add_c(add_cout), .add_v(add_ovf),
    .c_keep(carry_in), .v_keep(ovf_in),
    .n(flag_n), .z(flag_z), .c(flag_c), .v(flag_v)
  );
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   op_sel,
  input logic         carry_in,
  input logic         ovf_in,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v,
  input logic         arith_sel
);
  logic [W:0] plain_sum;
  assign plain_sum = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    AST_N_IS_MSB: assert (flag_n == result[W-1]); // R10
    AST_Z_IS_ZERO: assert (flag_z == (result == '0)); // R10
    if (!arith_sel) begin
      AST_KEEP_C: assert (flag_c == carry_in); // R9
      AST_KEEP_V: assert (flag_v == ovf_in); // R9
    end
    if (op_sel == 4'b0000) begin
      AST_ADD_SUM: assert ({flag_c, result} == plain_sum); // R1
      AST_ADD_OVF: assert (flag_v == ((op_a[W-1] == op_b[W-1]) && (result[W-1] != op_a[W-1]))); // R4
    end
    if (op_sel == 4'b0001) begin
      AST_SUB_NOBORROW: assert (flag_c == (op_a >= op_b)); // R2
    end
    if (op_sel == 4'b0101) begin
      AST_PASS_A: assert (result == op_a); // R6
    end
    if (op_sel == 4'b1110) begin
      AST_CONST_ZERO: assert (result == '0); // R8
    end
  end
endmodule

bind alu16_core alu16_core_chk #(.W(W)) chk_i (.*);

// File: tb/alu16_core_tb.sv
module alu16_core_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [W-1:0] op_a, op_b, result;
  logic [3:0]   op_sel;
  logic         carry_in, ovf_in;
  logic         flag_n, flag_z, flag_c, flag_v;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  alu16_core #(.W(W)) dut_i (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .carry_in(carry_in),
    .ovf_in(ovf_in), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'b0000, 4'b1000: return "R1";
      4'b0001, 4'b1001: return "R2";
      4'b1010, 4'b1011: return "R3";
      4'b0010, 4'b0011, 4'b0100, 4'b1100: return "R5";
      4'b0101, 4'b0110, 4'b1101: return "R6";
      4'b0111: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Model: {flags n,z,c,v, result}, built from signed/unsigned 64-bit math
  function automatic logic [W+3:0] model(input logic [3:0] s, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic ci,
                                         input logic vi);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint ur, sr;
    logic [W-1:0] r;
    logic c = ci, v = vi;
    longint k = 0;
    case (s)
      4'b0000, 4'b1000: begin
        k  = (s == 4'b1000) ? longint'(ci) : 0;
        ur = ua + ub + k; sr = sa + sb + k;
        r = ur[W-1:0]; c = (ur >= 64'sd4294967296);
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      4'b0001, 4'b1001, 4'b1010, 4'b1011: begin
        longint ux, uy, sx, sy;
        k = (s == 4'b1001 || s == 4'b1011) ? 1 - longint'(ci) : 0;
        if (s[3:1] == 3'b101) begin ux = ub; uy = ua; sx = sb; sy = sa; end
        else begin ux = ua; uy = ub; sx = sa; sy = sb; end
        ur = ux - uy - k; sr = sx - sy - k;
        r = ur[W-1:0];
        c = (ux > uy) || (ux == uy && k == 0);
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      4'b0010: r = a & b;
      4'b0011: r = a | b;
      4'b0100: r = a ^ b;
      4'b1100: r = a & ~b;
      4'b0101: r = a;
      4'b0110: r = b;
      4'b1101: r = ~b;
      4'b0111: begin ur = longint'(unsigned'(ua * ub)); r = ur[W-1:0]; end
      4'b1110: r = '0;
      default: r = 32'd1;
    endcase
    return {r[W-1], (r == '0), c, v, r};
  endfunction

  task automatic run_case(input logic [3:0] s, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic ci, input logic vi);
    logic [W+3:0] exp, got;
    @(negedge clk);
    op_sel = s; op_a = a; op_b = b; carry_in = ci; ovf_in = vi;
    #5;
    exp = model(s, a, b, ci, vi);
    got = {flag_n, flag_z, flag_c, flag_v, result};
    n_tests++;
    if (got[W-1:0] != exp[W-1:0]) begin
      n_fail++;
      $display("FAIL %s sel=%b a=%h b=%h ci=%b result %h expected %h",
               req_of(s), s, a, b, ci, got[W-1:0], exp[W-1:0]);
    end else if (got[W+3:W+2] != exp[W+3:W+2]) begin
      n_fail++;
      $display("FAIL R10 sel=%b nz %b expected %b", s, got[W+3:W+2], exp[W+3:W+2]);
    end else if (got[W+1:W] != exp[W+1:W]) begin
      n_fail++;
      $display("FAIL %s sel=%b a=%h b=%h ci=%b cv %b expected %b",
               (s[3:1] == 3'b000 || s[3:2] == 2'b10) ? "R4" : "R9",
               s, a, b, ci, got[W+1:W], exp[W+1:W]);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      $display("FAIL watchdog expired: cycles %0d expected below 100000", cycles);
      n_fail++;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [4];
    void'($urandom(32'd1234));
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    op_sel = 4'b1110; op_a = '0; op_b = '0; carry_in = 1'b0; ovf_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Initial state: zero constant sets Z (R8, R10)
    run_case(4'b1110, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b1);
    // Directed: add overflow into sign bit (R1, R4)
    run_case(4'b0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
    // Directed: equal subtract, no borrow, zero (R2)
    run_case(4'b0001, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1);
    // Directed: reverse subtract with borrow (R3)
    run_case(4'b1011, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0);
    // Directed: non-arithmetic keeps incoming flags (R9)
    run_case(4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_case(4'b1111, 32'h0, 32'h0, 1'b0, 1'b1);
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int ci = 0; ci < 2; ci++)
            run_case(4'(s), corner[i], corner[j], 1'(ci), 1'(i ^ j));
      for (int r = 0; r < 40; r++)
        run_case(4'(s), $urandom, $urandom, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule